// File: doc/BRIEF.md
# Part-present capture latch bank

This block keeps one capture bit per dispensing head and records whether a part was sensed while that head's valve drive was on. A head firing starts a new capture window for that head: the rising edge of its valve signal empties the bit. While the valve stays on, an active sensor input sets the bit. The bit then keeps its value until the same head fires again, so the host can read it at any time in between.

Three write-triggered commands support troubleshooting. A command is issued by writing a 1 to a small offset inside the card's register window. The first command empties every capture bit at once. The second drives a fixed-length test pulse towards the external sense boards, which makes them report a part. The third opens every capture bit to its sensor for the same fixed time, with no pulse, so that a bit stuck in one state can be found. Sensor inputs are expected to be synchronised and debounced already. The window length is derived from the clock frequency parameter.

Top module: `part_capture_bank`

## Requirements
- R1: A rising edge on `valve_on[i]` (high now, low in the previous cycle) makes `part_seen[i]` 0 in the next cycle. Other channels are not affected.
- R2: When `valve_on[i]` has been high for at least one full cycle and `sense_in[i]` is high, `part_seen[i]` is 1 in the next cycle.
- R3: A bit that is 1 stays 1 across any later valve or sensor activity until that head's next valve rising edge or a bulk clear.
- R4: With `valve_on[i]` low and the open window inactive, `sense_in[i]` has no effect on `part_seen[i]`.
- R5: A write (`wr_en`=1) of `wr_data`=1 to offset 6 makes every `part_seen` bit 0 in the next cycle.
- R6: A write of 1 to offset 8 raises `test_pulse` from the next cycle for exactly WIN cycles, where WIN = CLK_HZ*WINDOW_US/1e6. It does not touch the capture bits.
- R7: A write of 1 to offset 10 (0xA) raises `latch_open` from the next cycle for WIN cycles. While it is high, `sense_in[i]` sets `part_seen[i]` whatever the valve state, and `test_pulse` is not raised.
- R8: A new trigger to offset 8 or 0xA while its window is running reloads that window to a full WIN cycles.
- R9: When a clear (a valve rising edge or a bulk clear) and a set condition fall on the same channel in the same cycle, the bit becomes 0.
- R10: A write with `wr_data`=0, a write to any other offset, or address and data present while `wr_en`=0 changes nothing.
- R11: While `rst_n` is low, every capture bit, `test_pulse` and `latch_open` is 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valve_on | input | NUM_HEADS | Valve drive state per head, 1 = firing |
| sense_in | input | NUM_HEADS | Debounced part sensor per head, 1 = part present |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register offset within the card window |
| wr_data | input | 1 | Written value, 1 triggers the command |
| part_seen | output | NUM_HEADS | Capture bits |
| test_pulse | output | 1 | Test pulse to the external sense boards |
| latch_open | output | 1 | All-latch enable window active |

## Verification
A clear and a set can fall on one channel in the same cycle. One case is a valve rising edge while the sensor is already high. The other is a bulk-clear write while a valve is held on with its sensor high. The bench produces both cases on purpose: it raises the sensor before the valve, and it issues the clear write during a held firing. It expects the bit to read 0 in the following cycle and to be set again one cycle later. A randomised phase then mixes valve toggles, sensor activity and all three commands, and the behavioural model is compared with the outputs on every clock.

// File: rtl/pcap_pkg.sv
// Shared definitions for the part-present capture latch bank.
// Holds the command offsets that the host decodes and the command struct
// passed from the decoder to the datapath.
package pcap_pkg;

    localparam int OFS_CLEAR_ALL = 6;
    localparam int OFS_TEST_GO   = 8;
    localparam int OFS_OPEN_GO   = 10;

    typedef struct packed {
        logic clear_all;
        logic test_go;
        logic open_go;
    } pcap_cmd_t;

endpackage

// File: rtl/pcap_decode.sv
// Command decoder.
// Turns one register write strobe into single-cycle command requests.
// Assumes that a command is triggered only by writing a 1. Any other
// offset or value is ignored.
module pcap_decode
    import pcap_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    output pcap_cmd_t         cmd
);

    logic fire;

    // A write carries a command only when its data bit is 1
    assign fire = wr_en && wr_data;

    // Offset compare for each command
    always_comb begin
        cmd.clear_all = fire && (wr_addr == ADDR_W'(OFS_CLEAR_ALL));
        cmd.test_go   = fire && (wr_addr == ADDR_W'(OFS_TEST_GO));
        cmd.open_go   = fire && (wr_addr == ADDR_W'(OFS_OPEN_GO));
    end

endmodule

// File: rtl/pcap_window.sv
// Retriggerable fixed-length window timer.
// A start loads the down-counter with LOAD, and the window is active while
// the counter is not zero. A start during a running window reloads it.
// Assumes LOAD >= 1 and that LOAD fits in CNT_W bits.
module pcap_window #(
    parameter int CNT_W = 8,
    parameter int LOAD  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);

    logic [CNT_W-1:0] remain;

    // Load on start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CNT_W'(LOAD);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // The window is open while time remains
    assign active = (remain != '0);

endmodule

// File: rtl/pcap_channel.sv
// One capture channel.
// Clears on the valve's rising edge. Sets when the sensor is high while the
// valve is held on, or while the global open window is active. A clear
// always wins over a set. The sensor input is assumed to be synchronous
// already.
module pcap_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic valve,
    input  logic sense,
    input  logic open_win,
    input  logic clear_all,
    output logic seen
);

    logic valve_d;
    logic rise;
    logic held;
    logic want_set;

    // Edge and hold detection against the registered previous valve value
    assign rise     = valve && !valve_d;
    assign held     = valve && valve_d;
    assign want_set = sense && (held || open_win);

    // Remember the previous valve value
    always_ff @(posedge clk) begin
        if (!rst_n) valve_d <= 1'b0;
        else        valve_d <= valve;
    end

    // Capture bit: clear has priority over set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
        end else if (clear_all || rise) begin
            seen <= 1'b0;
        end else if (want_set) begin
            seen <= 1'b1;
        end
    end

endmodule

// File: rtl/part_capture_bank.sv
// Part-present capture latch bank, top level.
// Decodes the three host commands, runs the test-pulse and open windows,
// and holds one capture channel per head. The window length is
// CLK_HZ*WINDOW_US/1e6 cycles.
module part_capture_bank
    import pcap_pkg::*;
#(
    parameter int NUM_HEADS = 20,
    parameter int CLK_HZ    = 125_000_000,
    parameter int WINDOW_US = 2000,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_HEADS-1:0] valve_on,
    input  logic [NUM_HEADS-1:0] sense_in,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 wr_data,
    output logic [NUM_HEADS-1:0] part_seen,
    output logic                 test_pulse,
    output logic                 latch_open
);

    localparam longint WIN_L   = (longint'(CLK_HZ) * longint'(WINDOW_US)) / 64'd1000000;
    localparam int     WIN_CYC = (WIN_L < 1) ? 1 : int'(WIN_L);
    localparam int     CNT_W   = $clog2(WIN_CYC + 1);

    pcap_cmd_t cmd;

    // Host command decode
    pcap_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cmd    (cmd)
    );

    // Test pulse window towards the sense boards
    pcap_window #(.CNT_W(CNT_W), .LOAD(WIN_CYC)) u_test_win (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd.test_go),
        .active(test_pulse)
    );

    // Window that opens every latch to its sensor
    pcap_window #(.CNT_W(CNT_W), .LOAD(WIN_CYC)) u_open_win (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd.open_go),
        .active(latch_open)
    );

    // One capture channel per head
    for (genvar h = 0; h < NUM_HEADS; h++) begin : g_head
        pcap_channel u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .valve    (valve_on[h]),
            .sense    (sense_in[h]),
            .open_win (latch_open),
            .clear_all(cmd.clear_all),
            .seen     (part_seen[h])
        );
    end

endmodule

// File: rtl/pcap_checker.sv
// Property checker for part_capture_bank, attached through bind.
// Keeps its own record of the previous valve values and its own counter for
// the pulse length, and relates them to the top-level ports.
module pcap_checker
    import pcap_pkg::*;
#(
    parameter int NUM_HEADS = 20,
    parameter int ADDR_W    = 4,
    parameter int WIN_CYC   = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_HEADS-1:0] valve_on,
    input logic [NUM_HEADS-1:0] sense_in,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic                 wr_data,
    input logic [NUM_HEADS-1:0] part_seen,
    input logic                 test_pulse,
    input logic                 latch_open
);

    logic [NUM_HEADS-1:0] v_prev;
    logic clr_req, test_req, open_req;
    int   run_len;

    assign clr_req  = wr_en && wr_data && (wr_addr == ADDR_W'(OFS_CLEAR_ALL));
    assign test_req = wr_en && wr_data && (wr_addr == ADDR_W'(OFS_TEST_GO));
    assign open_req = wr_en && wr_data && (wr_addr == ADDR_W'(OFS_OPEN_GO));

    // Independent record of the previous valve values
    always_ff @(posedge clk) begin
        if (!rst_n) v_prev <= '0;
        else        v_prev <= valve_on;
    end

    // Count consecutive pulse cycles since the last trigger
    always_ff @(posedge clk) begin
        if (!rst_n)          run_len <= 0;
        else if (test_req)   run_len <= 0;
        else if (test_pulse) run_len <= run_len + 1;
        else                 run_len <= 0;
    end

    p_bulk_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (part_seen == '0));
    p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        test_req |=> test_pulse);
    p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= WIN_CYC);
    p_open_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        open_req |=> latch_open);

    for (genvar i = 0; i < NUM_HEADS; i++) begin : g_chk
        p_rise_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (valve_on[i] && !v_prev[i]) |=> !part_seen[i]);
        p_held_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (valve_on[i] && v_prev[i] && sense_in[i] && !clr_req) |=> part_seen[i]);
        p_keep_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (part_seen[i] && !(valve_on[i] && !v_prev[i]) && !clr_req) |=> part_seen[i]);
        p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!valve_on[i] && !latch_open && !part_seen[i]) |=> !part_seen[i]);
    end

endmodule

bind part_capture_bank pcap_checker #(
    .NUM_HEADS(NUM_HEADS),
    .ADDR_W   (ADDR_W),
    .WIN_CYC  (WIN_CYC)
) u_pcap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valve_on  (valve_on),
    .sense_in  (sense_in),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .part_seen (part_seen),
    .test_pulse(test_pulse),
    .latch_open(latch_open)
);

// File: tb/tb_part_capture_bank.sv
`timescale 1ns/1ps
module tb_part_capture_bank;

    localparam int N   = 20;
    localparam int HZ  = 10_000;
    localparam int WIN = 20;   // HZ * 2000 us / 1e6

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] valve_on = '0;
    logic [N-1:0] sense_in = '0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_addr = '0;
    logic         wr_data = 1'b0;
    logic [N-1:0] part_seen;
    logic         test_pulse;
    logic         latch_open;

    part_capture_bank #(.NUM_HEADS(N), .CLK_HZ(HZ), .WINDOW_US(2000), .ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .valve_on(valve_on), .sense_in(sense_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .part_seen(part_seen), .test_pulse(test_pulse), .latch_open(latch_open)
    );

    always #4 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    started = 0;
    string cur_req = "R11";

    // Behavioural reference model
    logic [N-1:0] m_seen = '0;
    logic [N-1:0] m_prev = '0;
    int           m_tc = 0;
    int           m_ec = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_seen = '0; m_prev = '0; m_tc = 0; m_ec = 0;
        end else begin
            bit clr, tg, og;
            clr = wr_en && wr_data && wr_addr == 4'd6;
            tg  = wr_en && wr_data && wr_addr == 4'd8;
            og  = wr_en && wr_data && wr_addr == 4'd10;
            for (int i = 0; i < N; i++) begin
                bit rise, setc;
                rise = valve_on[i] && !m_prev[i];
                setc = sense_in[i] && ((valve_on[i] && m_prev[i]) || m_ec > 0);
                if (clr || rise) m_seen[i] = 1'b0;
                else if (setc)   m_seen[i] = 1'b1;
            end
            m_tc = tg ? WIN : (m_tc > 0 ? m_tc - 1 : 0);
            m_ec = og ? WIN : (m_ec > 0 ? m_ec - 1 : 0);
            m_prev = valve_on;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare with the model on every falling edge
    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, 32'(part_seen), 32'(m_seen));
            chk(cur_req, 32'(test_pulse), 32'(m_tc > 0));
            chk(cur_req, 32'(latch_open), 32'(m_ec > 0));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int len;
        step(3);
        started = 1;
        cur_req = "R11";
        chk("R11", 32'(part_seen), 0);
        chk("R11", 32'(test_pulse), 0);
        chk("R11", 32'(latch_open), 0);
        rst_n = 1'b1;
        step(2);

        // Fire head 3 and sense a part mid-firing
        cur_req = "R2";
        valve_on[3] = 1'b1; step(2);
        sense_in[3] = 1'b1; step(1);
        sense_in[3] = 1'b0; step(2);
        valve_on[3] = 1'b0; step(3);
        chk("R2", 32'(part_seen[3]), 1);
        cur_req = "R3";
        sense_in[3] = 1'b1; step(2); sense_in[3] = 1'b0; step(2);
        chk("R3", 32'(part_seen[3]), 1);

        // Sensor with valve off has no effect
        cur_req = "R4";
        sense_in[5] = 1'b1; step(3); sense_in[5] = 1'b0; step(1);
        chk("R4", 32'(part_seen[5]), 0);

        // Refire head 3 with sensor already high: clear wins on the edge
        cur_req = "R9";
        sense_in[3] = 1'b1; valve_on[3] = 1'b1; step(1);
        chk("R1", 32'(part_seen[3]), 0);
        step(1);
        chk("R2", 32'(part_seen[3]), 1);
        valve_on[3] = 1'b0; sense_in[3] = 1'b0; step(2);

        // Bulk clear while head 7 holds a set condition
        cur_req = "R5";
        valve_on[7] = 1'b1; sense_in[7] = 1'b1; step(3);
        wr(4'd6, 1'b1);
        chk("R5", 32'(part_seen), 0);
        step(1);
        chk("R9", 32'(part_seen[7]), 1);
        valve_on[7] = 1'b0; sense_in[7] = 1'b0; step(2);

        // Ignored writes
        cur_req = "R10";
        wr(4'd6, 1'b0); wr(4'd7, 1'b1); wr(4'd5, 1'b1); wr(4'd9, 1'b1);
        @(negedge clk); wr_addr = 4'd6; wr_data = 1'b1;
        @(negedge clk); wr_addr = '0; wr_data = 1'b0;
        chk("R10", 32'(part_seen[7]), 1);
        chk("R10", 32'(test_pulse), 0);
        chk("R10", 32'(latch_open), 0);

        // Test pulse length
        cur_req = "R6";
        wr(4'd8, 1'b1);
        len = 0;
        while (test_pulse && len < 100) begin len++; @(negedge clk); end
        chk("R6", 32'(len), 32'(WIN));
        chk("R6", 32'(part_seen[7]), 1);

        // Retrigger reloads the window
        cur_req = "R8";
        wr(4'd8, 1'b1);
        step(9);
        wr(4'd8, 1'b1);
        step(WIN - 2);
        chk("R8", 32'(test_pulse), 1);
        step(4);

        // Open window sets latches without valves and without a pulse
        cur_req = "R7";
        wr(4'd10, 1'b1);
        step(3);
        sense_in[10] = 1'b1; step(1); sense_in[10] = 1'b0; step(1);
        chk("R7", 32'(part_seen[10]), 1);
        chk("R7", 32'(test_pulse), 0);
        step(WIN + 2);
        cur_req = "R4";
        sense_in[11] = 1'b1; step(2); sense_in[11] = 1'b0; step(1);
        chk("R4", 32'(part_seen[11]), 0);

        // Mixed randomised activity
        cur_req = "R9";
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                if (($urandom % 8) == 0) valve_on[i] = ~valve_on[i];
                if (($urandom % 4) == 0) sense_in[i] = ~sense_in[i];
            end
            if (($urandom % 23) == 0) begin
                wr_en = 1'b1;
                wr_addr = 4'(6 + 2 * ($urandom % 3));
                wr_data = 1'($urandom % 2);
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        step(2);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule